// File: doc/BRIEF.md
# Four-Port Set/Clear GPIO Controller

This block is a memory-mapped general-purpose I/O controller for four ports of unequal width. Software never has to read, modify and write back a port word. Each port has write-only "set" and "clear" registers for its output latches, and a second set/clear pair for its direction bits. Three read-only views show the latched direction, the latched output values and the synchronized pad levels. Ports 0, 1 and 2 are plain bidirectional ports with 8, 24 and 13 pins.

Port 3 is irregular. It has 24 pins that can only drive, 26 pins that can only sense, and 6 bidirectional pins. The bidirectional pins are controlled at one bit range of the port 3 output and direction words, but report their pad level at a different bit range of the port 3 input word. Every pad input passes through a two-flop synchronizer before software can see it.

The bus is a single-cycle register bus with a word address, a write strobe, write data and combinational read data.

Top module: `gpio_multiport`

## Requirements
- R1: After reset, every output latch and direction bit is 0. All pad outputs and output enables are therefore low, and every readable register reads 0 until a pad input is seen.
- R2: The word address is {port[1:0], code[2:0]}. The codes are: 0 output set, 1 output clear, 2 direction set, 3 direction clear, 4 direction state, 5 output state, 6 input state, 7 reserved. Writes take effect at the clock edge that samples the write strobe.
- R3: A write to an output set or direction set register forces to 1 every mapped bit written as 1, and leaves all other bits unchanged.
- R4: A write to an output clear or direction clear register forces to 0 every mapped bit written as 1, and leaves all other bits unchanged.
- R5: For ports 0 to 2, pin n drives the output latch bit n, and its output enable is direction bit n, where 1 means output.
- R6: The output state register returns the latched output values whatever level the pads carry.
- R7: A pad level change becomes visible in the input state register after exactly two clock edges. After one edge the old level still reads.
- R8: The port 3 output-only pins are driven from bits 0 to 23 of the port 3 output latch.
- R9: Port 3 bidirectional pin k uses bit 25+k of the port 3 output latch and of the port 3 direction register.
- R10: In the port 3 input state word, input-only pins 0 to 9 sit at bits 0 to 9, bidirectional pad k sits at bit 10+k, and input-only pins 10 to 25 sit at bits 16 to 31.
- R11: Bits that map to no pin read as 0, and writes to them are ignored. Widths are 8, 24 and 13 for ports 0 to 2. For port 3, output bits 24 and 31 are unmapped, and direction bits 0 to 24 and bit 31 are unmapped.
- R12: The four write-only registers and the reserved code read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address {port, code} |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| p0_pad_i | input | 8 | Port 0 pad levels |
| p0_pad_o | output | 8 | Port 0 pad drive values |
| p0_pad_oe | output | 8 | Port 0 output enables |
| p1_pad_i | input | 24 | Port 1 pad levels |
| p1_pad_o | output | 24 | Port 1 pad drive values |
| p1_pad_oe | output | 24 | Port 1 output enables |
| p2_pad_i | input | 13 | Port 2 pad levels |
| p2_pad_o | output | 13 | Port 2 pad drive values |
| p2_pad_oe | output | 13 | Port 2 output enables |
| p3_gpi_i | input | 26 | Port 3 input-only pad levels |
| p3_gpo_o | output | 24 | Port 3 output-only pad values |
| p3_bio_i | input | 6 | Port 3 bidirectional pad levels |
| p3_bio_o | output | 6 | Port 3 bidirectional pad drive values |
| p3_bio_oe | output | 6 | Port 3 bidirectional output enables |

## Verification
The bench builds the block with its default widths: 8, 24 and 13 bits for ports 0 to 2, 24 output-only, 26 input-only and 6 bidirectional port 3 pins, with the bidirectional control at bit 25 and their input report at bit 10. Because 13 and 24 leave unused upper bits, all-ones writes show the masking of unmapped bits on every port. The default port 3 layout lets one input pattern show whether the scattered input groups land in the right places. It also lets clear writes show whether the split output and direction ranges are decoded correctly.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    localparam int WORD_W = 32;
    localparam int NPORT  = 4;
    localparam int PSEL_W = $clog2(NPORT);
    localparam int CODE_W = 3;
    localparam int ADDR_W = PSEL_W + CODE_W;

    localparam int P0_W = 8;
    localparam int P1_W = 24;
    localparam int P2_W = 13;

    localparam int P3_GPO_W       = 24;
    localparam int P3_GPI_W       = 26;
    localparam int P3_BIO_W       = 6;
    localparam int P3_BIO_OUT_LSB = 25;
    localparam int P3_BIO_IN_LSB  = 10;
    localparam int P3_GPI_LO_W    = P3_BIO_IN_LSB;
    localparam int P3_GPI_HI_W    = P3_GPI_W - P3_GPI_LO_W;

    typedef enum logic [CODE_W-1:0] {
        RC_OUT_SET  = 3'd0,
        RC_OUT_CLR  = 3'd1,
        RC_DIR_SET  = 3'd2,
        RC_DIR_CLR  = 3'd3,
        RC_DIR_STAT = 3'd4,
        RC_OUT_STAT = 3'd5,
        RC_IN_STAT  = 3'd6,
        RC_RSVD     = 3'd7
    } regcode_e;

    function automatic logic [WORD_W-1:0] low_ones(input int n);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = (i < n);
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] out_mask(input int p);
        case (p)
            0:       return low_ones(P0_W);
            1:       return low_ones(P1_W);
            2:       return low_ones(P2_W);
            default: return low_ones(P3_GPO_W) | (low_ones(P3_BIO_W) << P3_BIO_OUT_LSB);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] dir_mask(input int p);
        if (p == NPORT - 1) return low_ones(P3_BIO_W) << P3_BIO_OUT_LSB;
        return out_mask(p);
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] wmask;

    always_comb begin
        wmask = wdata & MASK;
        st_d  = st_q;
        if (set_we) st_d.bits = st_d.bits | wmask;
        if (clr_we) st_d.bits = st_d.bits & ~wmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;

    // R3
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));

    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata & MASK)) == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(q));

endmodule

// File: rtl/gpio_multiport.sv
module gpio_multiport
    import gpio_mp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [P0_W-1:0]      p0_pad_i,
    output logic [P0_W-1:0]      p0_pad_o,
    output logic [P0_W-1:0]      p0_pad_oe,
    input  logic [P1_W-1:0]      p1_pad_i,
    output logic [P1_W-1:0]      p1_pad_o,
    output logic [P1_W-1:0]      p1_pad_oe,
    input  logic [P2_W-1:0]      p2_pad_i,
    output logic [P2_W-1:0]      p2_pad_o,
    output logic [P2_W-1:0]      p2_pad_oe,
    input  logic [P3_GPI_W-1:0]  p3_gpi_i,
    output logic [P3_GPO_W-1:0]  p3_gpo_o,
    input  logic [P3_BIO_W-1:0]  p3_bio_i,
    output logic [P3_BIO_W-1:0]  p3_bio_o,
    output logic [P3_BIO_W-1:0]  p3_bio_oe
);

    logic [PSEL_W-1:0] port_sel;
    regcode_e          code;

    assign port_sel = bus_addr[ADDR_W-1:CODE_W];
    assign code     = regcode_e'(bus_addr[CODE_W-1:0]);

    logic [NPORT-1:0][WORD_W-1:0] out_q;
    logic [NPORT-1:0][WORD_W-1:0] dir_q;
    logic [NPORT-1:0][WORD_W-1:0] raw_in;
    logic [NPORT-1:0][WORD_W-1:0] in_q;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic hit;
        assign hit = bus_we && (port_sel == PSEL_W'(g));

        gpio_setclr_bank #(.W(WORD_W), .MASK(out_mask(g))) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (hit && (code == RC_OUT_SET)),
            .clr_we (hit && (code == RC_OUT_CLR)),
            .wdata  (bus_wdata),
            .q      (out_q[g])
        );

        gpio_setclr_bank #(.W(WORD_W), .MASK(dir_mask(g))) u_dir (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (hit && (code == RC_DIR_SET)),
            .clr_we (hit && (code == RC_DIR_CLR)),
            .wdata  (bus_wdata),
            .q      (dir_q[g])
        );
    end

    assign raw_in[0] = {{(WORD_W-P0_W){1'b0}}, p0_pad_i};
    assign raw_in[1] = {{(WORD_W-P1_W){1'b0}}, p1_pad_i};
    assign raw_in[2] = {{(WORD_W-P2_W){1'b0}}, p2_pad_i};
    assign raw_in[3] = {p3_gpi_i[P3_GPI_W-1:P3_GPI_LO_W], p3_bio_i, p3_gpi_i[P3_GPI_LO_W-1:0]};

    gpio_sync2 #(.W(NPORT*WORD_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (in_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (code)
            RC_DIR_STAT: bus_rdata = dir_q[port_sel];
            RC_OUT_STAT: bus_rdata = out_q[port_sel];
            RC_IN_STAT:  bus_rdata = in_q[port_sel];
            default:     bus_rdata = '0;
        endcase
    end

    assign p0_pad_o  = out_q[0][P0_W-1:0];
    assign p0_pad_oe = dir_q[0][P0_W-1:0];
    assign p1_pad_o  = out_q[1][P1_W-1:0];
    assign p1_pad_oe = dir_q[1][P1_W-1:0];
    assign p2_pad_o  = out_q[2][P2_W-1:0];
    assign p2_pad_oe = dir_q[2][P2_W-1:0];
    assign p3_gpo_o  = out_q[3][P3_GPO_W-1:0];
    assign p3_bio_o  = out_q[3][P3_BIO_OUT_LSB +: P3_BIO_W];
    assign p3_bio_oe = dir_q[3][P3_BIO_OUT_LSB +: P3_BIO_W];

    // R6
    outstate_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == {PSEL_W'(0), RC_OUT_STAT}) |-> (bus_rdata[P0_W-1:0] == p0_pad_o));

    // R9
    bio_dir_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == {PSEL_W'(3), RC_DIR_STAT}) |-> (bus_rdata[P3_BIO_OUT_LSB +: P3_BIO_W] == p3_bio_oe));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == {PSEL_W'(2), RC_OUT_STAT}) |-> (bus_rdata[WORD_W-1:P2_W] == '0));

endmodule

// File: tb/gpio_multiport_test.sv
`timescale 1ns/1ps
module gpio_multiport_test;
    import gpio_mp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic [P0_W-1:0] p0_pad_i = '0, p0_pad_o, p0_pad_oe;
    logic [P1_W-1:0] p1_pad_i = '0, p1_pad_o, p1_pad_oe;
    logic [P2_W-1:0] p2_pad_i = '0, p2_pad_o, p2_pad_oe;
    logic [P3_GPI_W-1:0] p3_gpi_i = '0;
    logic [P3_GPO_W-1:0] p3_gpo_o;
    logic [P3_BIO_W-1:0] p3_bio_i = '0, p3_bio_o, p3_bio_oe;

    always #4 clk = ~clk;

    gpio_multiport uut (.*);

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [31:0] obs(input int s);
        case (s)
            0: return bus_rdata;
            1: return 32'(p0_pad_o);
            2: return 32'(p0_pad_oe);
            3: return 32'(p1_pad_o);
            4: return 32'(p1_pad_oe);
            5: return 32'(p2_pad_o);
            6: return 32'(p2_pad_oe);
            7: return 32'(p3_gpo_o);
            8: return 32'(p3_bio_o);
            default: return 32'(p3_bio_oe);
        endcase
    endfunction

    function automatic logic [4:0] A(input int p, input int c);
        return {p[1:0], c[2:0]};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        bus_addr = a;
        sb.push_back('{0, e, r});
    endtask

    task automatic pin(input int s, input logic [31:0] e, input string r);
        @(negedge clk);
        sb.push_back('{s, e, r});
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                got = obs(it.sel);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A(0,5), 32'h0, "R1 p0 out state");
        rd(A(3,4), 32'h0, "R1 p3 dir state");
        rd(A(1,6), 32'h0, "R1 p1 in state");
        pin(2, 32'h0, "R1 p0 oe");
        pin(9, 32'h0, "R1 p3 bio oe");
        pin(7, 32'h0, "R1 p3 gpo");
        // R3 set, R4 clear, R5 pad drive, R2 decode
        wr(A(0,0), 32'hA5);
        rd(A(0,5), 32'hA5, "R3 R2 p0 set");
        pin(1, 32'hA5, "R5 p0 pad drive");
        wr(A(0,0), 32'h0F);
        rd(A(0,5), 32'hAF, "R3 set keeps others");
        wr(A(0,1), 32'h21);
        rd(A(0,5), 32'h8E, "R4 clear keeps others");
        // R6 output state independent of pads
        @(negedge clk) p0_pad_i = 8'h5A;
        rd(A(0,5), 32'h8E, "R6 out state vs pad");
        // direction, R5
        wr(A(0,2), 32'h0F);
        pin(2, 32'h0F, "R5 p0 oe set");
        rd(A(0,4), 32'h0F, "R3 p0 dir state");
        wr(A(0,3), 32'h03);
        pin(2, 32'h0C, "R4 p0 oe clear");
        // R11 masking on ports 1, 2
        wr(A(1,0), 32'hFFFFFFFF);
        rd(A(1,5), 32'h00FFFFFF, "R11 p1 out mask");
        pin(3, 32'h00FFFFFF, "R5 p1 pad drive");
        wr(A(1,2), 32'hFFFFFFFF);
        rd(A(1,4), 32'h00FFFFFF, "R11 p1 dir mask");
        pin(4, 32'h00FFFFFF, "R5 p1 oe");
        wr(A(2,0), 32'hFFFFFFFF);
        rd(A(2,5), 32'h00001FFF, "R11 p2 out mask");
        wr(A(2,1), 32'h00001000);
        pin(5, 32'h00000FFF, "R4 p2 pad drive");
        // R12 write-only and reserved read zero
        rd(A(0,0), 32'h0, "R12 out set reads 0");
        rd(A(1,1), 32'h0, "R12 out clr reads 0");
        rd(A(3,2), 32'h0, "R12 dir set reads 0");
        rd(A(2,7), 32'h0, "R12 reserved reads 0");
        // R8 R9 port 3 outputs
        wr(A(3,0), 32'hFFFFFFFF);
        rd(A(3,5), 32'h7EFFFFFF, "R11 R8 R9 p3 out mask");
        pin(7, 32'h00FFFFFF, "R8 p3 gpo");
        pin(8, 32'h0000003F, "R9 p3 bio out");
        wr(A(3,2), 32'hFFFFFFFF);
        rd(A(3,4), 32'h7E000000, "R11 p3 dir mask");
        pin(9, 32'h0000003F, "R9 p3 bio oe");
        wr(A(3,1), 32'h02800001);
        rd(A(3,5), 32'h7C7FFFFE, "R4 p3 clear");
        pin(7, 32'h007FFFFE, "R8 p3 gpo after clear");
        pin(8, 32'h0000003E, "R9 p3 bio after clear");
        wr(A(3,3), 32'h04000000);
        pin(9, 32'h0000003D, "R9 p3 oe after clear");
        // R7 synchronizer latency
        @(negedge clk) p0_pad_i = 8'h3C;
        rd(A(0,6), 32'h5A, "R7 one edge old value");
        rd(A(0,6), 32'h3C, "R7 two edges new value");
        // R10 port 3 input layout, R11 zero-extension
        @(negedge clk);
        p3_gpi_i = {16'hA5C3, 10'h2B6};
        p3_bio_i = 6'h2D;
        p1_pad_i = 24'h123456;
        p2_pad_i = 13'h1ABC;
        repeat (2) @(negedge clk);
        rd(A(3,6), 32'hA5C3B6B6, "R10 p3 input layout");
        rd(A(1,6), 32'h00123456, "R11 p1 input");
        rd(A(2,6), 32'h00001ABC, "R11 p2 input");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule